// File: doc/BRIEF.md
# Addressed Multidrop Serial Receiver

This block receives asynchronous serial frames that carry eight data bits. It can optionally carry a ninth bit. Several receivers share one line, and each block drops the frames meant for other stations in hardware, so its host sees a receive flag only for traffic it should act on. The line is oversampled by a tick that runs at sixteen times the bit rate. A two-flop synchronizer brings the line into the clock domain first.

A controller with five states runs the receiver. In IDLE it waits for a tick on which the line reads low, then moves to START. START holds for one bit period. If the majority vote around mid-bit reads high, the start is a glitch and the controller goes back to IDLE; otherwise it moves to DATA. DATA shifts in eight bits, least significant first. After the last data bit it moves to NINTH when long frames are selected, or straight to STOP otherwise. NINTH captures one extra bit and then moves to STOP. STOP samples the stop bit and always returns to IDLE. At the end of STOP the block updates the framing-error flag and decides whether the frame is taken.

When filtering is enabled, a frame is taken only if its qualifying bit is 1 and its byte hits one of two addresses. The qualifying bit is the ninth bit for long frames and the stop bit for short frames. The two addresses are the masked station address and the broadcast address.

Top module: `mprx_receiver`

## Requirements
- R1: After reset, `rx_data_o` is 0x00, `rx_bit9_o` is 0, `rx_done_o` is 0 and `frame_err_o` is 0.
- R2: With `frame9_i`=1, a frame is start(0), eight data bits LSB first, a ninth bit, then stop. With filtering off, a taken frame loads the byte into `rx_data_o`, loads the ninth bit into `rx_bit9_o`, and sets `rx_done_o`.
- R3: With `frame9_i`=0, a frame is start, eight data bits LSB first, then stop. `rx_bit9_o` is loaded with the sampled stop bit.
- R4: Each bit is the majority of the samples taken on oversample ticks 7, 8 and 9 of its period. A start whose vote is high is dropped and the controller returns to IDLE. A spike covering a single tick does not change a bit.
- R5: Once set, `rx_done_o` stays high until `flag_clr_i` is asserted. A frame that ends while the flag is set and not being cleared leaves `rx_data_o` and `rx_bit9_o` unchanged.
- R6: At the end of every frame, `frame_err_o` becomes 1 if the stop bit voted low, and 0 otherwise.
- R7: With `mp_en_i`=1 and `frame9_i`=1, a frame whose ninth bit is 0 never sets `rx_done_o`.
- R8: With filtering on, a byte matches the station address when it equals `addr_i` in every position where `mask_i` is 1. For example, with addr 0x56 and mask 0xFC, bytes 0x54 to 0x57 are taken and 0x58 is dropped.
- R9: With `mask_i`=0xFF, only the exact `addr_i` matches through the station address.
- R10: The broadcast address is `addr_i | mask_i`. A byte that has 1 in every position where that OR is 1 is taken. For example, 0xFE is taken with addr 0x56 and mask 0xFC, while 0x7E is dropped.
- R11: With `mp_en_i`=1 and `frame9_i`=0, a matching byte is taken only when its stop bit is 1.
- R12: With `mp_en_i`=0, every frame is taken while the flag is clear, whatever its byte, ninth bit or stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd_i | input | 1 | Serial line, idle high |
| tick16_i | input | 1 | One-cycle pulse at 16x the bit rate |
| frame9_i | input | 1 | 1 selects frames with a ninth bit |
| mp_en_i | input | 1 | Enables address filtering |
| addr_i | input | 8 | Station address |
| mask_i | input | 8 | Address mask, 1 = compare |
| flag_clr_i | input | 1 | Clears the receive flag |
| rx_data_o | output | 8 | Last taken byte |
| rx_bit9_o | output | 1 | Ninth bit, or stop bit in short frames |
| rx_done_o | output | 1 | Receive flag |
| frame_err_o | output | 1 | Stop bit of the last frame was low |

## Verification
Unfiltered frames use alternating, edge-heavy and zero ninth-bit patterns. These show the bit order and the placement of the ninth bit apart from the stop bit. The masked sweep 0x54 to 0x58, together with an all-ones mask, separates the don't-care positions from the compared ones. Bytes such as 0xFE and 0x7E separate a broadcast hit from a station-address hit. Start glitches and mid-bit single-tick spikes separate the majority vote from a plain mid-bit sample. Frames sent while the flag is held show whether overwrite protection works.

// File: rtl/mprx_pkg.sv
package mprx_pkg;
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_NINTH,
        RX_STOP
    } rx_state_t;
endpackage

// File: rtl/mprx_sync.sv
module mprx_sync #(
    parameter int  STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= {STAGES{RST_VAL}};
        else        pipe <= {pipe[STAGES-2:0], d_i};
    end

    assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/mprx_vote.sv
module mprx_vote #(
    parameter int OVS  = 16,
    parameter int PH_W = $clog2(OVS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic            line_i,
    input  logic [PH_W-1:0] phase_i,
    output logic            vote_o
);
    localparam int MID = OVS / 2;

    logic [2:0] samp;

    // three taps centred on mid-bit
    for (genvar k = 0; k < 3; k++) begin : g_tap
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                samp[k] <= 1'b1;
            else if (tick_i && phase_i == PH_W'(MID - 1 + k))
                samp[k] <= line_i;
        end
    end

    assign vote_o = (samp[0] & samp[1]) | (samp[0] & samp[2]) | (samp[1] & samp[2]);
endmodule

// File: rtl/mprx_addr_match.sv
module mprx_addr_match #(
    parameter int W = 8
) (
    input  logic [W-1:0] byte_i,
    input  logic [W-1:0] addr_i,
    input  logic [W-1:0] mask_i,
    output logic         hit_o
);
    logic [W-1:0] bcast;
    logic         own_hit;
    logic         bc_hit;

    always_comb begin
        bcast   = addr_i | mask_i;
        own_hit = ((byte_i ^ addr_i) & mask_i) == '0;
        bc_hit  = (byte_i & bcast) == bcast;
        hit_o   = own_hit | bc_hit;
    end
endmodule

// File: rtl/mprx_receiver.sv
module mprx_receiver
    import mprx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd_i,
    input  logic              tick16_i,
    input  logic              frame9_i,
    input  logic              mp_en_i,
    input  logic [DATA_W-1:0] addr_i,
    input  logic [DATA_W-1:0] mask_i,
    input  logic              flag_clr_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_bit9_o,
    output logic              rx_done_o,
    output logic              frame_err_o
);
    localparam int PH_W  = $clog2(OVS);
    localparam int BIT_W = $clog2(DATA_W);

    rx_state_t         st, st_nx;
    logic              line_s;
    logic              vote;
    logic              hit;
    logic [PH_W-1:0]   phase;
    logic [BIT_W-1:0]  bit_idx;
    logic [DATA_W-1:0] shreg;
    logic              d8_q;
    logic              bit_end;
    logic              frame_end;
    logic              ninth_eff;
    logic              accept;
    logic              take;

    mprx_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (rxd_i),
        .q_o   (line_s)
    );

    mprx_vote #(.OVS(OVS), .PH_W(PH_W)) u_vote (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick16_i),
        .line_i  (line_s),
        .phase_i (phase),
        .vote_o  (vote)
    );

    mprx_addr_match #(.W(DATA_W)) u_match (
        .byte_i (shreg),
        .addr_i (addr_i),
        .mask_i (mask_i),
        .hit_o  (hit)
    );

    assign bit_end   = tick16_i && (phase == PH_W'(OVS - 1));
    assign frame_end = (st == RX_STOP) && bit_end;
    // short frames: stop bit stands in for the ninth bit
    assign ninth_eff = frame9_i ? d8_q : vote;
    assign accept    = !mp_en_i || (ninth_eff && hit);
    assign take      = frame_end && accept && (!rx_done_o || flag_clr_i);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RX_IDLE;
        else        st <= st_nx;
    end

    // transitions
    always_comb begin
        st_nx = st;
        unique case (st)
            RX_IDLE:  if (tick16_i && !line_s) st_nx = RX_START;
            RX_START: if (bit_end) st_nx = vote ? RX_IDLE : RX_DATA;
            RX_DATA:  if (bit_end && bit_idx == BIT_W'(DATA_W - 1))
                          st_nx = frame9_i ? RX_NINTH : RX_STOP;
            RX_NINTH: if (bit_end) st_nx = RX_STOP;
            RX_STOP:  if (bit_end) st_nx = RX_IDLE;
            default:  st_nx = RX_IDLE;
        endcase
    end

    // frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase   <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            d8_q    <= 1'b0;
        end else begin
            if (st == RX_IDLE)  phase <= '0;
            else if (tick16_i)  phase <= phase + 1'b1;
            if (st == RX_START) bit_idx <= '0;
            if (st == RX_DATA && bit_end) begin
                shreg   <= {vote, shreg[DATA_W-1:1]};
                bit_idx <= bit_idx + 1'b1;
            end
            if (st == RX_NINTH && bit_end) d8_q <= vote;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data_o   <= '0;
            rx_bit9_o   <= 1'b0;
            rx_done_o   <= 1'b0;
            frame_err_o <= 1'b0;
        end else begin
            if (frame_end) frame_err_o <= !vote;
            if (take) begin
                rx_data_o <= shreg;
                rx_bit9_o <= ninth_eff;
                rx_done_o <= 1'b1;
            end else if (flag_clr_i) begin
                rx_done_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/mprx_receiver_chk.sv
module mprx_receiver_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame9_i,
    input logic              mp_en_i,
    input logic [DATA_W-1:0] addr_i,
    input logic [DATA_W-1:0] mask_i,
    input logic              flag_clr_i,
    input logic [DATA_W-1:0] rx_data_o,
    input logic              rx_bit9_o,
    input logic              rx_done_o,
    input logic              frame_err_o
);
    assert_flag_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done_o && !flag_clr_i |=> rx_done_o);

    assert_flag_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_done_o) |-> $past(flag_clr_i));

    assert_no_overwrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done_o && !flag_clr_i |=> $stable(rx_data_o) && $stable(rx_bit9_o));

    assert_ninth_qual_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done_o) && $past(mp_en_i) && $past(frame9_i) |-> rx_bit9_o);

    assert_stop_qual_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done_o) && $past(mp_en_i) && !$past(frame9_i) |-> rx_bit9_o && !frame_err_o);

    assert_addr_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done_o) && $past(mp_en_i) |->
            ((((rx_data_o ^ $past(addr_i)) & $past(mask_i)) == '0) ||
             ((rx_data_o & ($past(addr_i) | $past(mask_i))) == ($past(addr_i) | $past(mask_i)))));
endmodule

bind mprx_receiver mprx_receiver_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame9_i    (frame9_i),
    .mp_en_i     (mp_en_i),
    .addr_i      (addr_i),
    .mask_i      (mask_i),
    .flag_clr_i  (flag_clr_i),
    .rx_data_o   (rx_data_o),
    .rx_bit9_o   (rx_bit9_o),
    .rx_done_o   (rx_done_o),
    .frame_err_o (frame_err_o)
);

// File: tb/sim_mprx_receiver.sv
`timescale 1ns/1ps
module sim_mprx_receiver;
    localparam int BITCLK = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       frame9 = 1'b1;
    logic       mp_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] mask = 8'h00;
    logic       flag_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit9;
    logic       rx_done;
    logic       frame_err;
    logic [1:0] tdiv = 2'd0;
    logic       tick16;

    int nchk = 0;
    int nerr = 0;
    logic [7:0] exp_d[$];
    logic       exp_b[$];
    string      exp_t[$];
    logic       done_q = 1'b0;

    always #2.5 clk = ~clk;

    always_ff @(posedge clk) tdiv <= tdiv + 2'd1;
    assign tick16 = (tdiv == 2'd0);

    mprx_receiver u0 (
        .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .tick16_i(tick16),
        .frame9_i(frame9), .mp_en_i(mp_en), .addr_i(addr), .mask_i(mask),
        .flag_clr_i(flag_clr), .rx_data_o(rx_data), .rx_bit9_o(rx_bit9),
        .rx_done_o(rx_done), .frame_err_o(frame_err)
    );

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected items when the flag rises
    always @(negedge clk) begin
        if (rst_n && rx_done && !done_q) begin
            if (exp_d.size() == 0) begin
                chk(1'b0, "unexpected flag R7/R8/R9/R10/R11", {8'h0, rx_data}, 16'h0);
            end else begin
                logic [7:0] ed;
                logic       eb;
                string      et;
                ed = exp_d.pop_front();
                eb = exp_b.pop_front();
                et = exp_t.pop_front();
                chk(rx_data == ed, {et, " data"}, {8'h0, rx_data}, {8'h0, ed});
                chk(rx_bit9 == eb, {et, " bit9"}, {15'h0, rx_bit9}, {15'h0, eb});
            end
        end
        done_q = rx_done;
    end

    task automatic put_bit(input logic v, input bit spike);
        if (spike) begin
            rxd = v;  repeat (30) @(negedge clk);
            rxd = ~v; repeat (4) @(negedge clk);
            rxd = v;  repeat (BITCLK - 34) @(negedge clk);
        end else begin
            rxd = v;  repeat (BITCLK) @(negedge clk);
        end
    endtask

    task automatic send_frame(input logic [7:0] d, input logic b8, input logic stp, input logic [7:0] spk);
        put_bit(1'b0, 1'b0);
        for (int i = 0; i < 8; i++) put_bit(d[i], spk[i]);
        if (frame9) put_bit(b8, 1'b0);
        put_bit(stp, 1'b0);
        rxd = 1'b1;
        repeat (96) @(negedge clk);
    endtask

    task automatic clear_flag();
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
    endtask

    task automatic expect_take(input logic [7:0] d, input logic b8, input logic stp, input string tag);
        exp_d.push_back(d);
        exp_b.push_back(frame9 ? b8 : stp);
        exp_t.push_back(tag);
        send_frame(d, b8, stp, 8'h00);
        chk(exp_d.size() == 0, {tag, " frame taken"}, 16'(exp_d.size()), 16'h0);
        exp_d.delete(); exp_b.delete(); exp_t.delete();
        clear_flag();
    endtask

    task automatic expect_drop(input logic [7:0] d, input logic b8, input logic stp, input string tag);
        send_frame(d, b8, stp, 8'h00);
        chk(rx_done == 1'b0, {tag, " frame dropped"}, {15'h0, rx_done}, 16'h0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(rx_data == 8'h00 && rx_bit9 == 1'b0, "R1 data/bit9", {7'h0, rx_bit9, rx_data}, 16'h0);
        chk(rx_done == 1'b0 && frame_err == 1'b0, "R1 flags", {14'h0, rx_done, frame_err}, 16'h0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);

        // R2/R12 long frames, filter off
        frame9 = 1'b1; mp_en = 1'b0;
        expect_take(8'hA5, 1'b1, 1'b1, "R2 A5");
        expect_take(8'h3C, 1'b0, 1'b1, "R12 3C ninth0");
        expect_take(8'h80, 1'b1, 1'b1, "R2 80");

        // R3 short frames
        frame9 = 1'b0;
        expect_take(8'h81, 1'b0, 1'b1, "R3 81");

        // R5 flag hold, no overwrite
        exp_d.push_back(8'h4D); exp_b.push_back(1'b1); exp_t.push_back("R5 first");
        send_frame(8'h4D, 1'b0, 1'b1, 8'h00);
        send_frame(8'h22, 1'b0, 1'b1, 8'h00);
        chk(rx_done == 1'b1, "R5 flag held", {15'h0, rx_done}, 16'h1);
        chk(rx_data == 8'h4D, "R5 data kept", {8'h0, rx_data}, 16'h4D);
        clear_flag();
        @(negedge clk);
        chk(rx_done == 1'b0, "R5 cleared", {15'h0, rx_done}, 16'h0);
        exp_d.delete(); exp_b.delete(); exp_t.delete();

        // R6 framing error, R12 taken anyway
        expect_take(8'h7E, 1'b0, 1'b0, "R6/R12 bad stop");
        chk(frame_err == 1'b1, "R6 error set", {15'h0, frame_err}, 16'h1);
        expect_take(8'h11, 1'b0, 1'b1, "R6 good stop");
        chk(frame_err == 1'b0, "R6 error cleared", {15'h0, frame_err}, 16'h0);

        // R4 start glitch rejected, then spikes do not flip bits
        frame9 = 1'b1;
        rxd = 1'b0; repeat (20) @(negedge clk);
        rxd = 1'b1; repeat (4 * BITCLK) @(negedge clk);
        chk(rx_done == 1'b0, "R4 start glitch", {15'h0, rx_done}, 16'h0);
        exp_d.push_back(8'h40); exp_b.push_back(1'b1); exp_t.push_back("R4 spikes");
        send_frame(8'h40, 1'b1, 1'b1, 8'h64);
        chk(exp_d.size() == 0, "R4 spike frame taken", 16'(exp_d.size()), 16'h0);
        exp_d.delete(); exp_b.delete(); exp_t.delete();
        clear_flag();

        // R8 masked station address, R7 ninth bit qualifies
        mp_en = 1'b1; addr = 8'h56; mask = 8'hFC;
        for (int b = 8'h54; b <= 8'h57; b++) expect_take(8'(b), 1'b1, 1'b1, "R8 in range");
        expect_drop(8'h58, 1'b1, 1'b1, "R8 58");
        expect_drop(8'h55, 1'b0, 1'b1, "R7 ninth0");
        // R10 broadcast
        expect_take(8'hFE, 1'b1, 1'b1, "R10 FE");
        expect_drop(8'h7E, 1'b1, 1'b1, "R10 7E");

        // R9 exact mask
        mask = 8'hFF;
        expect_take(8'h56, 1'b1, 1'b1, "R9 exact");
        expect_drop(8'h57, 1'b1, 1'b1, "R9 57");
        expect_take(8'hFF, 1'b1, 1'b1, "R10 FF");

        // R11 short frames filtered on stop bit
        frame9 = 1'b0;
        expect_take(8'h56, 1'b0, 1'b1, "R11 stop1");
        expect_drop(8'h56, 1'b0, 1'b0, "R11 stop0");
        chk(frame_err == 1'b1, "R11/R6 error", {15'h0, frame_err}, 16'h1);

        finish_run();
    end
endmodule